// File: doc/BRIEF.md
# Bridge Gate Enable Mapper

This block converts the per-phase drive assignment of a three-phase half-bridge set into six registered gate enables: one high-side and one low-side enable for each phase. Each phase can be assigned to the high rail, to the low rail, or left floating. The enables that result also depend on the present chop state: driving, fast decay or slow decay. Several other inputs shape the result too: the synchronous-rectification enable, a zero-current flag, a brake request, an active-low sleep input and a four-bit fault vector. The fault bits are over-temperature, low charge-pump voltage, low regulator voltage and logic undervoltage.

The inputs are decided in a fixed priority. Sleep or any fault comes first and turns everything off. Brake comes next and drives every low side. Normal commutation comes last. A per-phase dead-time counter sits between the decision and the output register. It keeps a phase from moving from one rail to the other without a programmable gap in which both of its enables are low. All inputs are synchronous. Every output is a flop, and it reflects the inputs sampled at the previous rising clock edge.

Top module: `bridge_gate_mapper`

## Requirements
- R1: While `rstN` is low, all six gate enables are low.
- R2: Phase i is commanded by `phaseCmd[2i+1:2i]`: 01 means high rail, 10 means low rail, and 00 or 11 means floating. With `chopState` = 00 (drive), a high-rail phase has its high-side enable on and a low-rail phase has its low-side enable on. The outputs change one clock after the inputs.
- R3: With `chopState` = 01 or 11 (fast decay) and synchronous rectification not active, all six enables go low.
- R4: In fast decay with synchronous rectification active (`srEn` high, `zeroCur` low), each high-rail phase turns on its low side and each low-rail phase turns on its high side.
- R5: With `chopState` = 10 (slow decay), low-rail phases keep their low side on. High-rail phases turn their low side on only when synchronous rectification is active. No high side is on.
- R6: `zeroCur` high cancels synchronous rectification: during decay the outputs match the `srEn` low case.
- R7: With `brake` high, and no sleep and no fault, no high side is on. Every low side is requested on, whatever the phase commands or chop state.
- R8: `sleepN` low, or any bit of `fault` high (bit 0 over-temperature, bit 1 charge pump low, bit 2 regulator low, bit 3 logic undervoltage), turns all enables off on the next clock. This overrides brake.
- R9: A phase never has its high-side and low-side enables on in the same cycle.
- R10: Once a gate of a phase turns off, the opposite gate of that phase stays off for `deadCycles`+1 cycles. A direct request to swap sides therefore gives exactly `deadCycles`+1 cycles with both enables of that phase low. A phase may turn the same side back on at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseCmd | input | 6 | Two-bit rail assignment per phase |
| chopState | input | 2 | 00 drive, 01/11 fast decay, 10 slow decay |
| srEn | input | 1 | Synchronous rectification enable |
| zeroCur | input | 1 | Winding current has reached zero |
| brake | input | 1 | Short all windings through the low sides |
| sleepN | input | 1 | Low puts the bridge to sleep (all off) |
| fault | input | 4 | Fault flags, any one set forces all off |
| deadCycles | input | 4 | Dead-time length N (gap is N+1 cycles) |
| hiGate | output | 3 | High-side gate enables, bit i is phase i |
| loGate | output | 3 | Low-side gate enables, bit i is phase i |

## Verification
Some properties are checked on every cycle. No phase may conduct through both of its gates at once. A side change must never follow the opposite gate in the next cycle. Sleep and fault must clear the bridge one clock later, brake must keep every high side dark, and plain fast decay and slow decay must never enable the wrong gates. Other behaviours can only be shown by the bench's scenarios: the exact length of the dead-time gap, the mapping of the reversed pair under rectified fast decay, the zero-current cutoff, and the fact that every fault bit acts on its own. The bench compares each output against a model that it computes on its own.

// File: rtl/gate_map_pkg.sv
package gate_map_pkg;

  typedef enum logic [1:0] {
    CHOP_DRIVE    = 2'b00,
    CHOP_FAST     = 2'b01,
    CHOP_SLOW     = 2'b10,
    CHOP_FAST_ALT = 2'b11
  } chop_e;

  typedef enum logic [1:0] {
    RAIL_FLOAT     = 2'b00,
    RAIL_HIGH      = 2'b01,
    RAIL_LOW       = 2'b10,
    RAIL_FLOAT_ALT = 2'b11
  } rail_e;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'b00,
    SIDE_HIGH = 2'b01,
    SIDE_LOW  = 2'b10
  } side_e;

  // Strobes from the priority/decay control to the per-phase datapath.
  typedef struct packed {
    logic forceOff;  // sleep or fault
    logic brakeAll;  // all low sides requested
    logic drive;     // normal mode, chop on
    logic fastSr;    // normal mode, fast decay, rectification active
    logic slowHold;  // normal mode, slow decay
    logic slowSr;    // normal mode, slow decay, rectification active
  } strobe_t;

endpackage

// File: rtl/gate_map_ctrl.sv
module gate_map_ctrl
  import gate_map_pkg::*;
#(
  parameter int FAULT_W = 4
) (
  input  logic [1:0]         chopState,
  input  logic               srEn,
  input  logic               zeroCur,
  input  logic               brake,
  input  logic               sleepN,
  input  logic [FAULT_W-1:0] fault,
  output strobe_t            strobe
);

  logic  srActive;
  logic  shutdown;
  logic  normalMode;
  chop_e chop;

  assign chop       = chop_e'(chopState);
  assign srActive   = srEn & ~zeroCur;
  assign shutdown   = ~sleepN | (|fault);
  assign normalMode = ~shutdown & ~brake;

  always_comb begin
    strobe          = '0;
    strobe.forceOff = shutdown;
    strobe.brakeAll = ~shutdown & brake;
    if (normalMode) begin
      unique case (chop)
        CHOP_DRIVE: strobe.drive = 1'b1;
        CHOP_FAST, CHOP_FAST_ALT: strobe.fastSr = srActive;
        CHOP_SLOW: begin
          strobe.slowHold = 1'b1;
          strobe.slowSr   = srActive;
        end
        default: strobe = strobe;
      endcase
    end
  end

endmodule

// File: rtl/gate_map_datapath.sv
module gate_map_datapath
  import gate_map_pkg::*;
#(
  parameter int PHASES = 3,
  parameter int DEAD_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2*PHASES-1:0]   phaseCmd,
  input  logic [DEAD_W-1:0]     deadCycles,
  input  strobe_t               strobe,
  output logic [PHASES-1:0]     hiGate,
  output logic [PHASES-1:0]     loGate
);

  localparam logic [DEAD_W-1:0] CNT_ZERO = '0;
  localparam logic [DEAD_W-1:0] CNT_ONE  = {{(DEAD_W-1){1'b0}}, 1'b1};

  for (genvar i = 0; i < PHASES; i++) begin : g_phase
    rail_e             rail;
    logic              wantHi, wantLo;
    logic              blockHi, blockLo;
    logic              nextHi, nextLo;
    logic              hiR, loR;
    side_e             lastSide;
    logic [DEAD_W-1:0] gapCnt;

    assign rail = rail_e'(phaseCmd[2*i +: 2]);

    // Requested gate pair before dead-time gating.
    always_comb begin
      wantHi = 1'b0;
      wantLo = 1'b0;
      if (strobe.forceOff) begin
        wantHi = 1'b0;
        wantLo = 1'b0;
      end else if (strobe.brakeAll) begin
        wantLo = 1'b1;
      end else begin
        unique case (rail)
          RAIL_HIGH: begin
            wantHi = strobe.drive;
            wantLo = strobe.fastSr | strobe.slowSr;
          end
          RAIL_LOW: begin
            wantHi = strobe.fastSr;
            wantLo = strobe.drive | strobe.slowHold;
          end
          default: begin
            wantHi = 1'b0;
            wantLo = 1'b0;
          end
        endcase
      end
    end

    // Dead-time gating: opposite side waits for the gap counter.
    always_comb begin
      blockHi = wantHi & (loR | ((lastSide == SIDE_LOW)  && (gapCnt != CNT_ZERO)));
      blockLo = wantLo & (hiR | ((lastSide == SIDE_HIGH) && (gapCnt != CNT_ZERO)));
      nextHi  = wantHi & ~blockHi;
      nextLo  = wantLo & ~blockLo;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hiR      <= 1'b0;
        loR      <= 1'b0;
        lastSide <= SIDE_NONE;
        gapCnt   <= CNT_ZERO;
      end else begin
        hiR <= nextHi;
        loR <= nextLo;
        if (nextHi)      lastSide <= SIDE_HIGH;
        else if (nextLo) lastSide <= SIDE_LOW;
        if ((hiR | loR) && !(nextHi | nextLo)) gapCnt <= deadCycles;
        else if (gapCnt != CNT_ZERO)           gapCnt <= gapCnt - CNT_ONE;
      end
    end

    assign hiGate[i] = hiR;
    assign loGate[i] = loR;
  end

endmodule

// File: rtl/bridge_gate_mapper.sv
module bridge_gate_mapper
  import gate_map_pkg::*;
#(
  parameter int PHASES  = 3,
  parameter int DEAD_W  = 4,
  parameter int FAULT_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2*PHASES-1:0]   phaseCmd,
  input  logic [1:0]            chopState,
  input  logic                  srEn,
  input  logic                  zeroCur,
  input  logic                  brake,
  input  logic                  sleepN,
  input  logic [FAULT_W-1:0]    fault,
  input  logic [DEAD_W-1:0]     deadCycles,
  output logic [PHASES-1:0]     hiGate,
  output logic [PHASES-1:0]     loGate
);

  strobe_t strobe;

  gate_map_ctrl #(.FAULT_W(FAULT_W)) u_ctrl (
    .chopState (chopState),
    .srEn      (srEn),
    .zeroCur   (zeroCur),
    .brake     (brake),
    .sleepN    (sleepN),
    .fault     (fault),
    .strobe    (strobe)
  );

  gate_map_datapath #(.PHASES(PHASES), .DEAD_W(DEAD_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .phaseCmd   (phaseCmd),
    .deadCycles (deadCycles),
    .strobe     (strobe),
    .hiGate     (hiGate),
    .loGate     (loGate)
  );

endmodule

// File: rtl/bridge_gate_mapper_chk.sv
module bridge_gate_mapper_chk #(
  parameter int PHASES  = 3,
  parameter int FAULT_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         chopState,
  input logic               srEn,
  input logic               zeroCur,
  input logic               brake,
  input logic               sleepN,
  input logic [FAULT_W-1:0] fault,
  input logic [PHASES-1:0]  hiGate,
  input logic [PHASES-1:0]  loGate
);

  logic normalIn;
  assign normalIn = sleepN && (fault == '0) && !brake;

  for (genvar i = 0; i < PHASES; i++) begin : g_ph
    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
      !(hiGate[i] && loGate[i])); // R9
    AST_HI_TO_LO_GAP: assert property (@(posedge clk) disable iff (!rstN)
      hiGate[i] |=> !loGate[i]); // R10
    AST_LO_TO_HI_GAP: assert property (@(posedge clk) disable iff (!rstN)
      loGate[i] |=> !hiGate[i]); // R10
  end

  AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepN || (fault != '0)) |=> (hiGate == '0 && loGate == '0)); // R8
  AST_BRAKE_NO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sleepN && (fault == '0) && brake) |=> (hiGate == '0)); // R7
  AST_FAST_PLAIN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (normalIn && chopState[0] && (!srEn || zeroCur)) |=> (hiGate == '0 && loGate == '0)); // R3
  AST_SLOW_NO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (normalIn && chopState == 2'b10) |=> (hiGate == '0)); // R5

endmodule

bind bridge_gate_mapper bridge_gate_mapper_chk #(.PHASES(PHASES), .FAULT_W(FAULT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chopState (chopState),
  .srEn      (srEn),
  .zeroCur   (zeroCur),
  .brake     (brake),
  .sleepN    (sleepN),
  .fault     (fault),
  .hiGate    (hiGate),
  .loGate    (loGate)
);

// File: tb/bridge_gate_mapper_tb.sv
module bridge_gate_mapper_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic [5:0] phaseCmd;
  logic [1:0] chopState;
  logic       srEn, zeroCur, brake, sleepN;
  logic [3:0] fault;
  logic [3:0] deadCycles;
  logic [2:0] hiGate, loGate;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  bit    mHi [3];
  bit    mLo [3];
  int    mLast [3];   // 0 none, 1 high, 2 low
  int    mCnt [3];
  string mTag;

  always #10 clk = ~clk;

  bridge_gate_mapper u_dut (
    .clk(clk), .rstN(rstN), .phaseCmd(phaseCmd), .chopState(chopState),
    .srEn(srEn), .zeroCur(zeroCur), .brake(brake), .sleepN(sleepN),
    .fault(fault), .deadCycles(deadCycles), .hiGate(hiGate), .loGate(loGate)
  );

  function automatic void targetOf(input int i, output bit th, output bit tl);
    bit off, srOk;
    int rail;
    off  = !sleepN || (fault != 0);
    srOk = srEn && !zeroCur;
    rail = int'(phaseCmd[2*i +: 2]);
    th = 0; tl = 0;
    if (off) return;
    if (brake) begin tl = 1; return; end
    if (rail == 1) begin
      if (chopState == 2'b00) th = 1;
      else if (srOk) tl = 1;                    // fast or slow with rectification
    end else if (rail == 2) begin
      if (chopState == 2'b00 || chopState == 2'b10) tl = 1;
      else if (srOk) th = 1;                    // fast rectified: reversed pair
    end
  endfunction

  function automatic string tagOf();
    if (!sleepN || fault != 0) return "R8";
    if (brake) return "R7";
    if (chopState == 2'b00) return "R2";
    if (srEn && zeroCur) return "R6";
    if (chopState == 2'b10) return "R5";
    if (srEn) return "R4";
    return "R3";
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 3; i++) begin
      mHi[i] = 0; mLo[i] = 0; mLast[i] = 0; mCnt[i] = 0;
    end
  endtask

  task automatic modelStep();
    mTag = tagOf();
    for (int i = 0; i < 3; i++) begin
      bit th, tl, nh, nl;
      targetOf(i, th, tl);
      nh = th && !(mLo[i] || (mLast[i] == 2 && mCnt[i] != 0));
      nl = tl && !(mHi[i] || (mLast[i] == 1 && mCnt[i] != 0));
      if ((th && !nh) || (tl && !nl)) mTag = "R10";
      if ((mHi[i] || mLo[i]) && !(nh || nl)) mCnt[i] = int'(deadCycles);
      else if (mCnt[i] != 0) mCnt[i] = mCnt[i] - 1;
      if (nh) mLast[i] = 1; else if (nl) mLast[i] = 2;
      mHi[i] = nh; mLo[i] = nl;
    end
  endtask

  task automatic checkOut(input string tag);
    logic [2:0] eh, el;
    for (int i = 0; i < 3; i++) begin eh[i] = mHi[i]; el[i] = mLo[i]; end
    checks++;
    if (hiGate !== eh || loGate !== el) begin
      fails++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, hiGate, loGate, eh, el);
    end
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (hiGate[i] && loGate[i]) begin
        fails++;
        $display("FAIL R9: phase %0d hi=1 lo=1 expected not both", i);
      end
    end
  endtask

  // Inputs are set right after a falling edge; the rising edge then samples them.
  task automatic tick();
    modelStep();
    @(negedge clk);
    checkOut(mTag);
  endtask

  task automatic setIdle();
    phaseCmd = 6'b00_00_00; chopState = 2'b00; srEn = 0; zeroCur = 0;
    brake = 0; sleepN = 1; fault = 4'h0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int gap;
    void'($urandom(32'd20240611));
    rstN = 0; deadCycles = 4'd2;
    setIdle();
    phaseCmd = 6'b10_00_01; // drive requested even during reset
    modelReset();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checkOut("R1");
    end
    rstN = 1;
    setIdle();

    // R2: drive mapping, A high, C low
    phaseCmd = 6'b10_00_01;
    for (int k = 0; k < 3; k++) tick();
    checks++;
    if (hiGate !== 3'b001 || loGate !== 3'b100) begin
      fails++; $display("FAIL R2: hi=%b lo=%b expected hi=001 lo=100", hiGate, loGate);
    end

    // R3: fast decay without rectification
    chopState = 2'b01; tick(); tick();
    // R4: fast decay rectified (after dead time)
    srEn = 1;
    for (int k = 0; k < 6; k++) tick();
    checks++;
    if (hiGate !== 3'b100 || loGate !== 3'b001) begin
      fails++; $display("FAIL R4: hi=%b lo=%b expected hi=100 lo=001", hiGate, loGate);
    end
    // R6: zero current cancels rectification
    zeroCur = 1; tick();
    checks++;
    if (hiGate !== 3'b000 || loGate !== 3'b000) begin
      fails++; $display("FAIL R6: hi=%b lo=%b expected hi=000 lo=000", hiGate, loGate);
    end
    // R5: slow decay
    zeroCur = 0; chopState = 2'b10;
    for (int k = 0; k < 6; k++) tick();
    checks++;
    if (hiGate !== 3'b000 || loGate !== 3'b101) begin
      fails++; $display("FAIL R5: hi=%b lo=%b expected hi=000 lo=101", hiGate, loGate);
    end

    // R10: exact gap on a direct side swap, N=3
    setIdle(); deadCycles = 4'd3; phaseCmd = 6'b00_00_01;
    for (int k = 0; k < 8; k++) tick();
    phaseCmd = 6'b00_00_10;
    gap = 0;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (loGate[0]) break;
      if (!hiGate[0]) gap++;
    end
    checks++;
    if (gap != 4 || !loGate[0]) begin
      fails++; $display("FAIL R10: gap=%0d lo=%b expected gap=4 lo=1", gap, loGate[0]);
    end
    // R10: same side may return at once
    phaseCmd = 6'b00_00_00; tick();
    phaseCmd = 6'b00_00_10; tick();
    checks++;
    if (loGate[0] !== 1'b1) begin
      fails++; $display("FAIL R10: same-side re-enable lo=%b expected 1", loGate[0]);
    end

    // R7: brake overrides commands
    phaseCmd = 6'b01_01_01; chopState = 2'b00; deadCycles = 4'd0;
    for (int k = 0; k < 3; k++) tick();
    brake = 1;
    for (int k = 0; k < 4; k++) tick();
    checks++;
    if (hiGate !== 3'b000 || loGate !== 3'b111) begin
      fails++; $display("FAIL R7: hi=%b lo=%b expected hi=000 lo=111", hiGate, loGate);
    end
    // R8: each fault bit alone beats brake, then sleep
    for (int b = 0; b < 4; b++) begin
      fault = 4'h0; tick(); tick();
      fault = 4'(1 << b); tick();
      checks++;
      if (hiGate !== 3'b000 || loGate !== 3'b000) begin
        fails++; $display("FAIL R8: fault bit %0d hi=%b lo=%b expected 000/000", b, hiGate, loGate);
      end
    end
    fault = 4'h0; tick(); tick();
    sleepN = 0; tick();
    checks++;
    if (hiGate !== 3'b000 || loGate !== 3'b000) begin
      fails++; $display("FAIL R8: sleep hi=%b lo=%b expected 000/000", hiGate, loGate);
    end

    // Constrained random traffic
    setIdle();
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 7) == 0) phaseCmd = 6'($urandom());
      if ($urandom_range(0, 3) == 0) chopState = 2'($urandom());
      if ($urandom_range(0, 9) == 0) srEn = ~srEn;
      zeroCur = ($urandom_range(0, 5) == 0);
      brake   = ($urandom_range(0, 24) == 0) ? ~brake : brake;
      sleepN  = ($urandom_range(0, 60) != 0);
      fault   = ($urandom_range(0, 50) == 0) ? 4'(1 << $urandom_range(0, 3)) : 4'h0;
      if ($urandom_range(0, 99) == 0) deadCycles = 4'($urandom_range(0, 5));
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule